// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register

This block holds the mode and status byte of a USB device's endpoint 0, the bidirectional control endpoint. Two agents share the byte. Firmware reaches it through a CPU read/write port. The serial interface engine reports bus events through one-cycle strobes. These strobes cover the start of a SETUP data packet, IN and OUT completion, the start of the ACK handshake, and a new endpoint mode value.

Any event from the engine locks the register against CPU writes. The lock stays on until firmware reads the register. This keeps firmware from wiping status that it has not yet seen. Firmware should therefore read back after every write, to learn whether the write took effect.

While a SETUP transfer is in progress, the SETUP flag is held at 1 and cannot be cleared. The same flag blocks CPU writes into the eight-byte endpoint 0 FIFO window. That window starts at a parameter address and has a parameter depth, with defaults 0xF8 and 8.

Top module: `ctlep_status`

## Requirements
- R1: After reset the register reads 0x00 and `locked` is 0.
- R2: An engine strobe sets its status flag on the next clock: bit 7 SETUP data start, bit 6 IN done, bit 5 OUT done, bit 4 ACK start. A mode strobe loads bits 3:0 from `eng_mode`. Any strobe sets `locked`.
- R3: While `locked` is 1, a CPU write leaves the register unchanged.
- R4: A read clears `locked` on the next clock, unless an engine strobe arrives in the same cycle.
- R5: A CPU write taken while unlocked clears bits 6:4 and loads bits 3:0 from `cpu_wdata[3:0]`. It also clears bit 7 when no SETUP window is open. Bits 7:4 of the written data have no effect.
- R6: A SETUP window opens with the SETUP data-start strobe and closes with the ACK-start strobe. While the window is open, bit 7 stays 1 even after accepted writes.
- R7: If an engine strobe and a CPU write fall in the same cycle, the strobe is applied, the write is dropped and `locked` is set.
- R8: `fifo_wr_block` equals bit 7. While it is 1, `fifo_wr_en` stays 0.
- R9: `fifo_wr_en` is 1 only when `fifo_wr` is 1, `fifo_addr` lies inside the FIFO window (0xF8 to 0xFF by default) and bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| cpu_rd | input | 1 | CPU read of the register (removes the lock) |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data; only bits 3:0 are stored |
| cpu_rdata | output | 8 | Current register value: flags in 7:4, mode in 3:0 |
| locked | output | 1 | 1 while CPU writes are ignored |
| fifo_wr | input | 1 | CPU write request into the endpoint 0 FIFO |
| fifo_addr | input | ADDR_W | Address of that FIFO write |
| fifo_wr_en | output | 1 | Qualified FIFO write strobe |
| fifo_wr_block | output | 1 | FIFO write inhibit (SETUP flag) |
| eng_setup_dstart | input | 1 | Strobe: SETUP data packet starts |
| eng_in_done | input | 1 | Strobe: IN transaction received |
| eng_out_done | input | 1 | Strobe: OUT transaction received |
| eng_ack_start | input | 1 | Strobe: ACK handshake starts |
| eng_mode_vld | input | 1 | Strobe: new mode on `eng_mode` |
| eng_mode | input | 4 | Mode value from the engine |

## Verification
Two collisions need checking: an engine update arriving in the same cycle as a CPU write, and the same update arriving in the cycle of a CPU read. Each collision is provoked by raising the CPU request and an engine strobe together for a single cycle.

The write collision is judged by the result: the strobe's flag appears, the old mode bits survive and the lock is set. The read collision is judged by `locked` staying at 1. A third case provokes a read and a write in the same cycle while locked; the write must be ignored and the lock must still be released.

// File: rtl/ctlep_pkg.sv
package ctlep_pkg;
  localparam int MODE_W = 4;
  localparam int FLAG_W = 4;
  localparam int REG_W  = FLAG_W + MODE_W;

  // flag order matches register bit order (setup is the top bit)
  typedef struct packed {
    logic setup;
    logic in_rx;
    logic out_rx;
    logic acked;
  } flags_t;

  typedef struct packed {
    logic              setup_dstart;
    logic              in_done;
    logic              out_done;
    logic              ack_start;
    logic              mode_vld;
    logic [MODE_W-1:0] mode;
  } eng_ev_t;
endpackage

// File: rtl/ctlep_rst_sync.sv
module ctlep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nx;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ctlep_lock.sv
module ctlep_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_upd,
  input  logic cpu_rd,
  output logic locked
);
  logic lock_q;
  logic lock_nx;
  logic lock_en;

  always_comb begin
    lock_en = eng_upd | cpu_rd;
    lock_nx = eng_upd;   // engine update wins over a read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_nx;
  end

  assign locked = lock_q;
endmodule

// File: rtl/ctlep_setup_hold.sv
module ctlep_setup_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_dstart,
  input  logic ack_start,
  output logic hold
);
  logic hold_q;
  logic hold_nx;
  logic hold_en;

  always_comb begin
    hold_en = setup_dstart | ack_start;
    hold_nx = setup_dstart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_nx;
  end

  assign hold = hold_q;
endmodule

// File: rtl/ctlep_stat_reg.sv
module ctlep_stat_reg
  import ctlep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  eng_ev_t           ev,
  input  logic              eng_upd,
  input  logic              wr_ok,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              hold,
  output flags_t            flags,
  output logic [MODE_W-1:0] mode
);
  flags_t            flags_q, flags_nx;
  logic [MODE_W-1:0] mode_q, mode_nx;
  logic              reg_en;

  always_comb begin
    flags_nx = flags_q;
    mode_nx  = mode_q;
    reg_en   = 1'b0;
    if (eng_upd) begin
      reg_en          = 1'b1;
      flags_nx.setup  = flags_q.setup  | ev.setup_dstart;
      flags_nx.in_rx  = flags_q.in_rx  | ev.in_done;
      flags_nx.out_rx = flags_q.out_rx | ev.out_done;
      flags_nx.acked  = flags_q.acked  | ev.ack_start;
      if (ev.mode_vld) mode_nx = ev.mode;
    end else if (wr_ok) begin
      reg_en         = 1'b1;
      flags_nx       = '0;
      flags_nx.setup = hold;          // SETUP window keeps the flag up
      mode_nx        = wr_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mode_q  <= '0;
    end else if (reg_en) begin
      flags_q <= flags_nx;
      mode_q  <= mode_nx;
    end
  end

  assign flags = flags_q;
  assign mode  = mode_q;
endmodule

// File: rtl/ctlep_fifo_gate.sv
module ctlep_fifo_gate #(
  parameter int unsigned             ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]       FIFO_BASE  = 8'hF8,
  parameter int unsigned             FIFO_DEPTH = 8
) (
  input  logic              fifo_wr,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic              block,
  output logic              fifo_wr_en
);
  localparam logic [ADDR_W-1:0] FIFO_LAST = FIFO_BASE + ADDR_W'(FIFO_DEPTH - 1);

  logic in_win;

  always_comb begin
    in_win     = (fifo_addr >= FIFO_BASE) && (fifo_addr <= FIFO_LAST);
    fifo_wr_en = fifo_wr & in_win & ~block;
  end
endmodule

// File: rtl/ctlep_status.sv
module ctlep_status
  import ctlep_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] FIFO_BASE  = 8'hF8,
  parameter int unsigned       FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              locked,
  input  logic              fifo_wr,
  input  logic [ADDR_W-1:0] fifo_addr,
  output logic              fifo_wr_en,
  output logic              fifo_wr_block,
  input  logic              eng_setup_dstart,
  input  logic              eng_in_done,
  input  logic              eng_out_done,
  input  logic              eng_ack_start,
  input  logic              eng_mode_vld,
  input  logic [MODE_W-1:0] eng_mode
);
  logic              rst_n_sync;
  eng_ev_t           ev;
  logic              eng_upd;
  logic              wr_ok;
  logic              hold;
  flags_t            flags;
  logic [MODE_W-1:0] mode;
  logic              wdata_unused;

  always_comb begin
    ev.setup_dstart = eng_setup_dstart;
    ev.in_done      = eng_in_done;
    ev.out_done     = eng_out_done;
    ev.ack_start    = eng_ack_start;
    ev.mode_vld     = eng_mode_vld;
    ev.mode         = eng_mode;
    eng_upd = eng_setup_dstart | eng_in_done | eng_out_done
            | eng_ack_start | eng_mode_vld;
    wr_ok   = cpu_wr & ~locked & ~eng_upd;
  end

  assign wdata_unused = ^cpu_wdata[REG_W-1:MODE_W];

  ctlep_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ctlep_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .eng_upd (eng_upd),
    .cpu_rd  (cpu_rd),
    .locked  (locked)
  );

  ctlep_setup_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .setup_dstart (eng_setup_dstart),
    .ack_start    (eng_ack_start),
    .hold         (hold)
  );

  ctlep_stat_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .ev      (ev),
    .eng_upd (eng_upd),
    .wr_ok   (wr_ok),
    .wr_mode (cpu_wdata[MODE_W-1:0]),
    .hold    (hold),
    .flags   (flags),
    .mode    (mode)
  );

  assign cpu_rdata     = {flags, mode};
  assign fifo_wr_block = flags.setup;

  ctlep_fifo_gate #(
    .ADDR_W     (ADDR_W),
    .FIFO_BASE  (FIFO_BASE),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_gate (
    .fifo_wr    (fifo_wr),
    .fifo_addr  (fifo_addr),
    .block      (fifo_wr_block),
    .fifo_wr_en (fifo_wr_en)
  );
endmodule

// File: rtl/ctlep_status_chk.sv
module ctlep_status_chk
  import ctlep_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] FIFO_BASE  = 8'hF8,
  parameter int unsigned       FIFO_DEPTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [REG_W-1:0]  cpu_wdata,
  input logic [REG_W-1:0]  cpu_rdata,
  input logic              locked,
  input logic              fifo_wr,
  input logic [ADDR_W-1:0] fifo_addr,
  input logic              fifo_wr_en,
  input logic              fifo_wr_block,
  input logic              eng_setup_dstart,
  input logic              eng_in_done,
  input logic              eng_out_done,
  input logic              eng_ack_start,
  input logic              eng_mode_vld
);
  localparam logic [ADDR_W-1:0] LAST = FIFO_BASE + ADDR_W'(FIFO_DEPTH - 1);

  logic upd;
  logic win_q;

  assign upd = eng_setup_dstart | eng_in_done | eng_out_done
             | eng_ack_start | eng_mode_vld;

  // independent tracker of the SETUP window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win_q <= 1'b0;
    else if (eng_setup_dstart) win_q <= 1'b1;
    else if (eng_ack_start)    win_q <= 1'b0;
  end

  p_engine_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> locked);

  p_in_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_in_done |=> cpu_rdata[REG_W-2]);

  p_locked_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cpu_wr && !upd) |=> $stable(cpu_rdata));

  p_read_unlocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !upd) |=> !locked);

  p_write_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && cpu_wr && !upd) |=>
      (cpu_rdata[REG_W-2:MODE_W] == '0) &&
      (cpu_rdata[MODE_W-1:0] == $past(cpu_wdata[MODE_W-1:0])));

  p_setup_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_q || eng_setup_dstart) && !eng_ack_start) |=> cpu_rdata[REG_W-1]);

  p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !locked && eng_in_done) |=> (locked && cpu_rdata[REG_W-2]));

  p_fifo_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_block |-> !fifo_wr_en);

  p_fifo_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> (fifo_wr && fifo_addr >= FIFO_BASE && fifo_addr <= LAST));
endmodule

bind ctlep_status ctlep_status_chk #(
  .ADDR_W     (ADDR_W),
  .FIFO_BASE  (FIFO_BASE),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n_sync),
  .cpu_rd           (cpu_rd),
  .cpu_wr           (cpu_wr),
  .cpu_wdata        (cpu_wdata),
  .cpu_rdata        (cpu_rdata),
  .locked           (locked),
  .fifo_wr          (fifo_wr),
  .fifo_addr        (fifo_addr),
  .fifo_wr_en       (fifo_wr_en),
  .fifo_wr_block    (fifo_wr_block),
  .eng_setup_dstart (eng_setup_dstart),
  .eng_in_done      (eng_in_done),
  .eng_out_done     (eng_out_done),
  .eng_ack_start    (eng_ack_start),
  .eng_mode_vld     (eng_mode_vld)
);

// File: tb/ctlep_status_bench.sv
`timescale 1ns/1ps
module ctlep_status_bench;
  logic       clk;
  logic       rst_n;
  logic       cpu_rd, cpu_wr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       locked;
  logic       fifo_wr;
  logic [7:0] fifo_addr;
  logic       fifo_wr_en, fifo_wr_block;
  logic       s_su, s_in, s_out, s_ack, s_mv;
  logic [3:0] s_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] val;
    logic       lk;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  ctlep_status u_ctlep_status (
    .clk (clk), .rst_n (rst_n),
    .cpu_rd (cpu_rd), .cpu_wr (cpu_wr), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .locked (locked),
    .fifo_wr (fifo_wr), .fifo_addr (fifo_addr),
    .fifo_wr_en (fifo_wr_en), .fifo_wr_block (fifo_wr_block),
    .eng_setup_dstart (s_su), .eng_in_done (s_in), .eng_out_done (s_out),
    .eng_ack_start (s_ack), .eng_mode_vld (s_mv), .eng_mode (s_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expected state and compares once the outputs have settled
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (cpu_rdata !== e.val || locked !== e.lk || fifo_wr_block !== e.val[7]) begin
          fails++;
          $display("FAIL %s: actual val=%h lock=%b blk=%b expected val=%h lock=%b blk=%b",
                   e.tag, cpu_rdata, locked, fifo_wr_block, e.val, e.lk, e.val[7]);
        end
      end
    end
  end

  task automatic step(input logic rd, input logic wr, input logic [7:0] wd,
                      input logic su, input logic in_d, input logic out_d,
                      input logic ack, input logic mv, input logic [3:0] md,
                      input logic [7:0] ev, input logic el, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    s_su = su; s_in = in_d; s_out = out_d; s_ack = ack; s_mv = mv; s_mode = md;
    @(posedge clk);
    #1;
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = 8'h00;
    s_su = 0; s_in = 0; s_out = 0; s_ack = 0; s_mv = 0; s_mode = 4'h0;
    e.val = ev; e.lk = el; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic fifo_try(input logic [7:0] addr, input logic exp_en, input string tag);
    @(negedge clk);
    #1;
    fifo_wr = 1'b1; fifo_addr = addr;
    #1;
    checks++;
    if (fifo_wr_en !== exp_en) begin
      fails++;
      $display("FAIL %s: actual fifo_wr_en=%b expected %b (addr %h)",
               tag, fifo_wr_en, exp_en, addr);
    end
    @(posedge clk);
    #1;
    fifo_wr = 1'b0; fifo_addr = 8'h00;
  endtask

  initial begin
    rst_n = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    fifo_wr = 0; fifo_addr = 0;
    s_su = 0; s_in = 0; s_out = 0; s_ack = 0; s_mv = 0; s_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    begin
      exp_t e;
      e.val = 8'h00; e.lk = 0; e.tag = "R1 reset";
      sb_q.push_back(e);
    end
    //    rd wr wd     su in ou ak mv md    exp   lk
    step(0, 1, 8'hF5, 0, 0, 0, 0, 0, 4'h0, 8'h05, 0, "R5 write clears high nibble");
    step(0, 0, 8'h00, 0, 1, 0, 0, 0, 4'h0, 8'h45, 1, "R2 IN flag and lock");
    step(0, 1, 8'h0A, 0, 0, 0, 0, 0, 4'h0, 8'h45, 1, "R3 locked write ignored");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, 4'h0, 8'h45, 0, "R4 read unlocks");
    step(0, 1, 8'h03, 0, 0, 0, 0, 0, 4'h0, 8'h03, 0, "R5 write clears IN");
    step(0, 0, 8'h00, 0, 0, 1, 0, 1, 4'h9, 8'h29, 1, "R2 OUT flag and mode");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, 4'h0, 8'h29, 0, "R4 read unlocks");
    step(0, 1, 8'h0C, 0, 0, 0, 1, 0, 4'h0, 8'h39, 1, "R7 engine beats write");
    step(1, 1, 8'h0E, 0, 0, 0, 0, 0, 4'h0, 8'h39, 0, "R3 read+write while locked");
    fifo_try(8'hF8, 1'b1, "R9 first FIFO byte");
    fifo_try(8'hF7, 1'b0, "R9 below window");
    fifo_try(8'h00, 1'b0, "R9 outside window");
    step(0, 0, 8'h00, 1, 0, 0, 0, 0, 4'h0, 8'hB9, 1, "R2 R6 SETUP start");
    fifo_try(8'hFF, 1'b0, "R8 FIFO blocked by SETUP");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, 4'h0, 8'hB9, 0, "R4 read unlocks");
    step(0, 1, 8'h01, 0, 0, 0, 0, 0, 4'h0, 8'h81, 0, "R6 SETUP held in window");
    step(0, 0, 8'h00, 0, 0, 0, 1, 0, 4'h0, 8'h91, 1, "R2 ACK start closes window");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, 4'h0, 8'h91, 0, "R4 read unlocks");
    step(0, 1, 8'h02, 0, 0, 0, 0, 0, 4'h0, 8'h02, 0, "R6 SETUP clears after window");
    fifo_try(8'hFF, 1'b1, "R9 last FIFO byte");
    step(1, 0, 8'h00, 0, 0, 0, 0, 1, 4'h7, 8'h07, 1, "R4 read loses to engine");
    @(negedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule